// File: doc/BRIEF.md
# TDM Frame Assembler with Per-Slot Parity

This block turns a set of parallel channel words into one serial time-division frame, one bit per clock. Each frame starts with a fixed 16-bit synchronization header. In burst mode an idle preamble comes before the header. After the header the block serves every channel once, in a fixed rotation. Each channel slot carries the payload bits, then an even-parity bit over that payload, then an idle guard gap. The gap length follows from a configurable nominal slot width. The next frame follows the last guard gap with no dead cycle in between.

Downstream logic gets two framing signals. The first is a one-cycle strobe on the first cycle of each frame. The second is a pulse that covers the first three cycles of the frame, so that receivers can restart together. All channel words, the burst-mode choice and the slot width are captured on the clock edge that opens a frame. The frame being sent cannot be torn by a source that changes in the middle of it.

The sequencer is an enumerated state machine with six states:
- `ST_IDLE` is the reset state, with all outputs low.
- `ST_PRE` sends the idle preamble.
- `ST_SYNC` shifts out the header.
- `ST_DATA` shifts out one channel's payload.
- `ST_PAR` sends that channel's parity bit.
- `ST_GUARD` holds the line idle for the gap.

The transitions are:
- `ST_IDLE` → `ST_PRE` (burst on) or `ST_SYNC` (burst off). This is the frame launch, and it captures the inputs.
- `ST_PRE` → `ST_SYNC` after the last preamble cycle.
- `ST_SYNC` → `ST_DATA` after the last header bit, with the channel index set to 0.
- `ST_DATA` → `ST_PAR` after the last payload bit.
- `ST_PAR` → `ST_GUARD` always.
- `ST_GUARD` → `ST_DATA` with the channel index incremented, when the gap ends and channels remain.
- `ST_GUARD` → `ST_PRE` or `ST_SYNC`, when the gap of the last channel ends. This is a new frame launch, and it captures the inputs again.
- Any state → `ST_IDLE` on synchronous reset.

Top module: `tdm_framer`

## Requirements
- R1: While `rst` is high, and in the cycle after the edge that sampled it high, all four outputs are 0. The first frame begins in the cycle after the first edge at which `rst` is low.
- R2: Every frame carries the header 0xF628 as 16 consecutive bits, most significant first, with `bit_vld` high.
- R3: If `burst_en` is 1 when a frame launches, 8 idle cycles come first (`ser_bit` 0, `bit_vld` 0) and then the header. If `burst_en` is 0, the header comes first.
- R4: After the header, channels 0, 1, 2, 3 follow in that order. Channel i is `ch_data[8*i+7:8*i]`, sent as 8 bits, most significant first, with `bit_vld` high. After channel 3's guard gap the next frame launches at once.
- R5: Right after each channel's payload comes one bit with `bit_vld` high, equal to the XOR of that channel's 8 payload bits.
- R6: Each parity bit is followed by a guard gap of max(1, floor(`slot_len`/5)) cycles, with `ser_bit` 0 and `bit_vld` 0.
- R7: `frm_start` is high for exactly one cycle per frame, in the frame's first cycle: the first preamble cycle, or else the first header bit.
- R8: `frm_rst` is high in exactly the first 3 cycles of each frame and low at all other times.
- R9: `ch_data`, `burst_en` and `slot_len` are sampled only on the edge that launches a frame. Changes at any other time do not affect the frame in progress.
- R10: Whenever `bit_vld` is 0, `ser_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_en | input | 1 | Prepend the idle preamble to the next frame |
| slot_len | input | SL_W (8) | Nominal slot width in cycles; sets the guard gap |
| ch_data | input | NUM_CH*CH_W (32) | Channel words, channel i at bits [i*CH_W +: CH_W] |
| ser_bit | output | 1 | Serial line bit |
| bit_vld | output | 1 | High when `ser_bit` carries header, payload or parity |
| frm_start | output | 1 | One-cycle strobe on the first cycle of a frame |
| frm_rst | output | 1 | Pulse over the first 3 cycles of a frame |

## Verification
The bench builds the block with its default parameters: 4 channels of 8 bits, an 8-bit slot width, the 0xF628 header, an 8-cycle preamble and a 3-cycle frame pulse. With an 8-bit slot width the guard gap ranges from the 1-cycle floor (slot widths 0 to 9) up to 51 cycles at a slot width of 255. This puts both the minimum clamp and the longest frames within reach. The run uses all-zero, all-one and random payloads, so parity takes both values. Burst mode is switched on and off between frames. Inputs change in the middle of frames, and a reset is applied mid-frame, to exercise launch-time capture and the return to idle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_DATA,
        ST_PAR,
        ST_GUARD
    } tdm_state_e;

endpackage

// File: rtl/tdm_guard_calc.sv
module tdm_guard_calc #(
    parameter int SL_W = 8
) (
    input  logic [SL_W-1:0] slot_len,
    output logic [SL_W-1:0] guard_len
);

    logic [SL_W-1:0] fifth;

    always_comb begin
        fifth = slot_len / SL_W'(5);
        if (fifth == '0) begin
            guard_len = SL_W'(1);
        end else begin
            guard_len = fifth;
        end
    end

    // R6: the gap length is never zero
    always_comb begin
        a_r6_guard_nonzero: assert (guard_len != '0);
    end

endmodule

// File: rtl/tdm_slot_hold.sv
module tdm_slot_hold #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 8,
    parameter int SL_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [NUM_CH*CH_W-1:0]        ch_data_i,
    input  logic [SL_W-1:0]               guard_i,
    output logic [NUM_CH-1:0][CH_W-1:0]   hold_o,
    output logic [NUM_CH-1:0]             par_o,
    output logic [SL_W-1:0]               guard_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o  <= '0;
            guard_o <= '0;
        end else if (load) begin
            for (int i = 0; i < NUM_CH; i++) begin
                hold_o[i] <= ch_data_i[i*CH_W +: CH_W];
            end
            guard_o <= guard_i;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_par
        assign par_o[g] = ^hold_o[g];
    end

    // R9: captured words do not move between frame launches
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_o));

    a_r9_guard_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(guard_o));

endmodule

// File: rtl/tdm_seq_fsm.sv
module tdm_seq_fsm
    import tdm_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CH_W    = 8,
    parameter int SL_W    = 8,
    parameter int SYNC_W  = 16,
    parameter int PRE_LEN = 8,
    parameter int RST_CYC = 3,
    localparam int LEN_A   = (SYNC_W > CH_W) ? SYNC_W : CH_W,
    localparam int LEN_MAX = (LEN_A > PRE_LEN) ? LEN_A : PRE_LEN,
    localparam int LEN_BW  = $clog2(LEN_MAX + 1),
    localparam int CNT_W   = (LEN_BW > SL_W) ? LEN_BW : SL_W,
    localparam int CH_IW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AGE_W   = $clog2(RST_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_en,
    input  logic [SL_W-1:0]  guard_len,
    output tdm_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic [CH_IW-1:0] ch_idx,
    output logic             load,
    output logic             first_cyc,
    output logic             rst_win
);

    tdm_state_e       nstate;
    logic [CNT_W-1:0] ncnt;
    logic [CH_IW-1:0] nch;
    logic [AGE_W-1:0] age;
    logic             launch;

    // next-state logic
    always_comb begin
        nstate = state;
        ncnt   = cnt + CNT_W'(1);
        nch    = ch_idx;
        launch = 1'b0;
        unique case (state)
            ST_IDLE: begin
                launch = 1'b1;
            end
            ST_PRE: begin
                if (cnt == CNT_W'(PRE_LEN - 1)) begin
                    nstate = ST_SYNC;
                    ncnt   = '0;
                end
            end
            ST_SYNC: begin
                if (cnt == CNT_W'(SYNC_W - 1)) begin
                    nstate = ST_DATA;
                    ncnt   = '0;
                    nch    = '0;
                end
            end
            ST_DATA: begin
                if (cnt == CNT_W'(CH_W - 1)) begin
                    nstate = ST_PAR;
                    ncnt   = '0;
                end
            end
            ST_PAR: begin
                nstate = ST_GUARD;
                ncnt   = '0;
            end
            ST_GUARD: begin
                if (cnt == CNT_W'(guard_len) - CNT_W'(1)) begin
                    if (ch_idx == CH_IW'(NUM_CH - 1)) begin
                        launch = 1'b1;
                    end else begin
                        nstate = ST_DATA;
                        ncnt   = '0;
                        nch    = ch_idx + CH_IW'(1);
                    end
                end
            end
            default: begin
                nstate = ST_IDLE;
                ncnt   = '0;
            end
        endcase
        if (launch) begin
            nstate = burst_en ? ST_PRE : ST_SYNC;
            ncnt   = '0;
        end
    end

    assign load = launch;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            ch_idx <= '0;
            age    <= AGE_W'(RST_CYC);
        end else begin
            state  <= nstate;
            cnt    <= ncnt;
            ch_idx <= nch;
            if (launch) begin
                age <= '0;
            end else if (age != AGE_W'(RST_CYC)) begin
                age <= age + AGE_W'(1);
            end
        end
    end

    assign first_cyc = (state != ST_IDLE) && (age == '0);
    assign rst_win   = (state != ST_IDLE) && (age < AGE_W'(RST_CYC));

    // R1: the cycle after reset is released shows the idle state
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> state == ST_IDLE);

    // R4: the slot after the header belongs to channel 0
    a_r4_first_channel: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_SYNC) |-> ch_idx == '0);

    // R4: each later slot moves on by exactly one channel
    a_r4_round_robin: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_GUARD)
            |-> ch_idx == $past(ch_idx) + CH_IW'(1));

    // R3: the preamble is always followed by the header
    a_r3_pre_to_sync: assert property (@(posedge clk) disable iff (rst)
        (state != ST_PRE && $past(state) == ST_PRE) |-> state == ST_SYNC);

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
    import tdm_pkg::*;
#(
    parameter int                NUM_CH    = 4,
    parameter int                CH_W      = 8,
    parameter int                SL_W      = 8,
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hF628,
    parameter int                PRE_LEN   = 8,
    parameter int                RST_CYC   = 3,
    localparam int               DW        = NUM_CH * CH_W,
    localparam int               LEN_A     = (SYNC_W > CH_W) ? SYNC_W : CH_W,
    localparam int               LEN_MAX   = (LEN_A > PRE_LEN) ? LEN_A : PRE_LEN,
    localparam int               LEN_BW    = $clog2(LEN_MAX + 1),
    localparam int               CNT_W     = (LEN_BW > SL_W) ? LEN_BW : SL_W,
    localparam int               CH_IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            burst_en,
    input  logic [SL_W-1:0] slot_len,
    input  logic [DW-1:0]   ch_data,
    output logic            ser_bit,
    output logic            bit_vld,
    output logic            frm_start,
    output logic            frm_rst
);

    tdm_state_e                 state;
    logic [CNT_W-1:0]           cnt;
    logic [CH_IW-1:0]           ch_idx;
    logic                       load;
    logic                       first_cyc;
    logic                       rst_win;
    logic [SL_W-1:0]            guard_new;
    logic [SL_W-1:0]            guard_held;
    logic [NUM_CH-1:0][CH_W-1:0] hold;
    logic [NUM_CH-1:0]          par;
    logic [CH_W-1:0]            cur_word;

    tdm_guard_calc #(
        .SL_W (SL_W)
    ) u_guard (
        .slot_len  (slot_len),
        .guard_len (guard_new)
    );

    tdm_slot_hold #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .SL_W   (SL_W)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ch_data_i (ch_data),
        .guard_i   (guard_new),
        .hold_o    (hold),
        .par_o     (par),
        .guard_o   (guard_held)
    );

    tdm_seq_fsm #(
        .NUM_CH  (NUM_CH),
        .CH_W    (CH_W),
        .SL_W    (SL_W),
        .SYNC_W  (SYNC_W),
        .PRE_LEN (PRE_LEN),
        .RST_CYC (RST_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .burst_en  (burst_en),
        .guard_len (guard_held),
        .state     (state),
        .cnt       (cnt),
        .ch_idx    (ch_idx),
        .load      (load),
        .first_cyc (first_cyc),
        .rst_win   (rst_win)
    );

    assign cur_word = hold[ch_idx];

    // output process
    always_comb begin
        ser_bit = 1'b0;
        bit_vld = 1'b0;
        unique case (state)
            ST_SYNC: begin
                bit_vld = 1'b1;
                ser_bit = |(SYNC_WORD & (SYNC_W'(1) << (CNT_W'(SYNC_W - 1) - cnt)));
            end
            ST_DATA: begin
                bit_vld = 1'b1;
                ser_bit = |(cur_word & (CH_W'(1) << (CNT_W'(CH_W - 1) - cnt)));
            end
            ST_PAR: begin
                bit_vld = 1'b1;
                ser_bit = par[ch_idx];
            end
            ST_IDLE, ST_PRE, ST_GUARD: begin
                bit_vld = 1'b0;
                ser_bit = 1'b0;
            end
            default: begin
                bit_vld = 1'b0;
                ser_bit = 1'b0;
            end
        endcase
    end

    assign frm_start = first_cyc;
    assign frm_rst   = rst_win;

    // R7: the frame strobe never lasts two cycles
    a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
        frm_start |=> !frm_start);

    // R8: the frame pulse covers the strobe cycle
    a_r8_pulse_with_start: assert property (@(posedge clk) disable iff (rst)
        frm_start |-> frm_rst);

    // R8: the frame pulse only ever begins at a frame start
    a_r8_pulse_begins_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_rst) |-> frm_start);

    // R10: the line is low whenever it carries nothing
    a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> !ser_bit);

endmodule

// File: tb/sim_tdm_framer.sv
module sim_tdm_framer;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 8;
    localparam int SL_W   = 8;
    localparam int DW     = NUM_CH * CH_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            burst_en = 1'b0;
    logic [SL_W-1:0] slot_len = 8'd10;
    logic [DW-1:0]   ch_data = '0;
    logic            ser_bit;
    logic            bit_vld;
    logic            frm_start;
    logic            frm_rst;

    int checks   = 0;
    int failures = 0;

    // expected per-cycle stream
    bit    q_bit[$];
    bit    q_vld[$];
    bit    q_fs[$];
    bit    q_fr[$];
    string q_tag[$];
    int    k_in_frame;

    always #10 clk = ~clk;

    tdm_framer u0 (
        .clk       (clk),
        .rst       (rst),
        .burst_en  (burst_en),
        .slot_len  (slot_len),
        .ch_data   (ch_data),
        .ser_bit   (ser_bit),
        .bit_vld   (bit_vld),
        .frm_start (frm_start),
        .frm_rst   (frm_rst)
    );

    task automatic push_item(input bit b, input bit v, input string tag);
        q_bit.push_back(b);
        q_vld.push_back(v);
        q_fs.push_back(k_in_frame == 0);
        q_fr.push_back(k_in_frame < 3);
        q_tag.push_back(tag);
        k_in_frame++;
    endtask

    task automatic build_frame();
        logic [15:0] hdr;
        int          gap;
        hdr = 16'hF628;
        gap = int'(slot_len) / 5;
        if (gap < 1) gap = 1;
        k_in_frame = 0;
        if (burst_en) begin
            for (int i = 0; i < 8; i++) push_item(1'b0, 1'b0, "R3");
        end
        for (int i = 15; i >= 0; i--) push_item(hdr[i], 1'b1, "R2");
        for (int c = 0; c < NUM_CH; c++) begin
            logic [CH_W-1:0] w;
            bit              p;
            w = ch_data[c*CH_W +: CH_W];
            p = 1'b0;
            for (int i = CH_W - 1; i >= 0; i--) begin
                push_item(w[i], 1'b1, "R4 R9");
                p = p ^ w[i];
            end
            push_item(p, 1'b1, "R5 R9");
            for (int i = 0; i < gap; i++) push_item(1'b0, 1'b0, "R6");
        end
    endtask

    task automatic check1(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // reference model: advance at the active edge using inputs the design sees
    always @(posedge clk) begin
        if (rst) begin
            q_bit.delete(); q_vld.delete(); q_fs.delete(); q_fr.delete(); q_tag.delete();
            k_in_frame = 0;
            q_bit.push_back(1'b0);
            q_vld.push_back(1'b0);
            q_fs.push_back(1'b0);
            q_fr.push_back(1'b0);
            q_tag.push_back("R1");
        end else if (q_bit.size() == 0) begin
            build_frame();
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (q_bit.size() != 0) begin
            bit    eb, ev, efs, efr;
            string tg;
            eb  = q_bit.pop_front();
            ev  = q_vld.pop_front();
            efs = q_fs.pop_front();
            efr = q_fr.pop_front();
            tg  = q_tag.pop_front();
            check1(tg, "ser_bit", int'(ser_bit), int'(eb));
            check1(tg, "bit_vld", int'(bit_vld), int'(ev));
            check1((tg == "R1") ? "R1" : "R7", "frm_start", int'(frm_start), int'(efs));
            check1((tg == "R1") ? "R1" : "R8", "frm_rst", int'(frm_rst), int'(efr));
            check1("R10", "ser_bit_when_idle", int'(ser_bit & ~bit_vld), 0);
        end
    end

    // stimulus
    initial begin
        logic [SL_W-1:0] slot_set[10];
        slot_set = '{8'd0, 8'd4, 8'd5, 8'd9, 8'd10, 8'd255, 8'd14, 8'd23, 8'd1, 8'd50};
        ch_data = 32'hA5_3C_0F_81;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 7000; c++) begin
            @(negedge clk);
            if (c % 400 == 399) begin
                slot_len = slot_set[(c / 400) % 10];
                burst_en = ~burst_en;
            end
            if (c == 1000) ch_data = '0;
            else if (c == 1500) ch_data = '1;
            else if (c == 1900) ch_data = 32'h01_80_7F_FE;
            else if ((c < 800 || c > 2200) && (c % 53 == 7)) ch_data = DW'($urandom);
            if (c == 3111) rst = 1'b1;
            if (c == 3113) rst = 1'b0;
        end
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1..R10 run hung actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule